// File: doc/BRIEF.md
# Label-Weighted Constraint Accumulator

This block forms the signed sum of a set of non-negative multipliers, each weighted by a class label of +1 or -1. It then reports whether that sum is negative or exactly zero. The labels are kept as one bit per pattern in a circular ring. A loader fills the ring one bit per cycle from the least significant bit of its data bus. During each evaluation pass the ring turns one place per pattern. The bit at the ring's head decides whether the current multiplier is added to the running total or subtracted from it.

A pass starts with a one-cycle start pulse. The accumulator clears on that edge. On each of the following `NUM_PAT` edges, the block takes in the multiplier that the external index counter presents for pattern 0, 1, 2 and so on, in that order. After the last addition a one-cycle done strobe appears. The sign and zero outputs then describe the finished total and keep that value until the next pass. Because the ring turns exactly `NUM_PAT` places per pass, it ends each pass in its starting alignment. A new pass can follow as soon as a fresh set of multipliers is ready.

Top module: `label_sum_sign`

## Requirements
- R1: After the asynchronous active-low reset, `sign_o` is 0, `zero_o` is 1 and `done_o` is 0, and every stored label is 0.
- R2: While the block is idle, a cycle with `lbl_shift` and `lbl_load` both high takes `lbl_sin` into the ring. After `NUM_PAT` such cycles, the first bit loaded is the label of pattern 0 and the last is the label of pattern `NUM_PAT-1`.
- R3: While the block is idle, a cycle with `lbl_shift` high and `lbl_load` low rotates the ring by one place without loss: pattern k then carries the label that pattern k+1 (modulo `NUM_PAT`) held, and `lbl_sin` is ignored.
- R4: A start pulse accepted while idle clears the total. On the k-th edge after it (k = 1..`NUM_PAT`), the block adds `alpha` if the label of pattern k-1 is 1 and subtracts it if the label is 0.
- R5: `done_o` is high for exactly one cycle. It rises on the `NUM_PAT`-th edge after the accepted start edge.
- R6: `sign_o` is the most significant bit of the two's-complement total, so it is 1 when the total is negative. `zero_o` is 1 exactly when the total is 0. Both keep their value from done until the next accepted start.
- R7: The total is `ALPHA_W + clog2(NUM_PAT) + 1` bits wide, so neither all-add nor all-subtract passes at full-scale `alpha` wrap.
- R8: A pass leaves the ring in its starting alignment, so a repeated pass over the same multipliers gives the same result.
- R9: While a pass is running, `start` and `lbl_shift` have no effect: the pass keeps its length and result, and the labels are unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lbl_sin | input | 1 | Label bit to load (data bus LSB; 1 = class +1, 0 = class -1) |
| lbl_shift | input | 1 | Shift enable for the label ring while idle |
| lbl_load | input | 1 | Load select: 1 takes `lbl_sin`, 0 recirculates |
| start | input | 1 | One-cycle pulse that begins a pass |
| alpha | input | ALPHA_W | Unsigned multiplier of the pattern being processed |
| sign_o | output | 1 | MSB of the total (1 = negative) |
| zero_o | output | 1 | High when the total equals zero |
| done_o | output | 1 | One-cycle strobe at the end of a pass |

## Verification
The assertions assume that `alpha` carries the multiplier of pattern k-1 on the k-th edge after start. They also assume that the total is only taken as meaningful from the done strobe onward. The bench drives each multiplier on the falling edge before the edge that consumes it. It holds `lbl_shift` low during passes, except in the case that deliberately pokes `start`, `lbl_shift` and `lbl_load` mid-pass. The full-scale label and multiplier patterns keep the overflow property at its limit.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   // width of a signed total able to hold np terms of an unsigned aw-bit value
   function automatic int total_bits(input int aw, input int np);
      return aw + $clog2(np) + 1;
   endfunction

endpackage

// File: rtl/label_ring.sv
module label_ring #(
   parameter int NUM_PAT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_en,     // take the external bit in at the top
   input  logic rot_en,    // recirculate the head bit to the top
   input  logic din_bit,
   input  logic pass_go,   // snapshot for the realignment check
   input  logic pass_fin,
   output logic head_bit
);

   logic [NUM_PAT-1:0] ring_q;
   logic [NUM_PAT-1:0] snap_q;
   logic               top_in;

   assign top_in   = ld_en ? din_bit : ring_q[0];
   assign head_bit = ring_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= '0;
      end else if (ld_en || rot_en) begin
         ring_q <= {top_in, ring_q[NUM_PAT-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (pass_go) begin
         snap_q <= ring_q;
      end
   end

   // R8: a full pass brings the labels back to where they started
   p_ring_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pass_fin |-> ring_q == snap_q);

   // R2/R3: loading and rotation never happen together
   p_ld_rot_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && rot_en));

endmodule

// File: rtl/pass_seq.sv
module pass_seq
   import lss_pkg::*;
#(
   parameter int NUM_PAT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic go,       // accepted start, clears the total
   output logic step_en,  // one pattern consumed this cycle
   output logic done
);

   localparam int CNT_W = $clog2(NUM_PAT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PAT - 1);

   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [CNT_W-1:0] chk_q;

   assign go      = start && (st_q == SEQ_IDLE);
   assign step_en = (st_q == SEQ_RUN);
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            st_q  <= SEQ_RUN;
            cnt_q <= '0;
         end else if (step_en) begin
            if (cnt_q == LAST) begin
               st_q   <= SEQ_IDLE;
               done_q <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // independent count of consumed patterns for the length check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_q <= '0;
      end else if (go) begin
         chk_q <= '0;
      end else if (step_en) begin
         chk_q <= chk_q + 1'b1;
      end
   end

   // R5: the strobe lasts one cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: done follows exactly NUM_PAT consumed patterns
   p_pass_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> chk_q == CNT_W'(NUM_PAT));

   // R9: a start during a pass does not cut it short
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && start && (chk_q < CNT_W'(NUM_PAT - 1)) |=> step_en);

endmodule

// File: rtl/signed_pick.sv
module signed_pick #(
   parameter int ALPHA_W   = 12,
   parameter int TOT_W     = 16,
   parameter int NEG_STYLE = 1   // 1: explicit invert-plus-one, 0: arithmetic minus
) (
   input  logic [ALPHA_W-1:0] alpha,
   input  logic               plus,
   output logic [TOT_W-1:0]   term
);

   logic [TOT_W-1:0] ext;
   logic [TOT_W-1:0] neg;

   assign ext = {{(TOT_W - ALPHA_W){1'b0}}, alpha};

   generate
      if (NEG_STYLE == 1) begin : g_inv
         assign neg = ~ext + TOT_W'(1);
      end else begin : g_sub
         assign neg = TOT_W'(0) - ext;
      end
   endgenerate

   assign term = plus ? ext : neg;

endmodule

// File: rtl/total_acc.sv
module total_acc #(
   parameter int TOT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [TOT_W-1:0] term,
   output logic [TOT_W-1:0] total
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
      end else if (clr) begin
         total <= '0;
      end else if (en) begin
         total <= total + term;
      end
   end

endmodule

// File: rtl/label_sum_sign.sv
module label_sum_sign
   import lss_pkg::*;
#(
   parameter int NUM_PAT   = 8,
   parameter int ALPHA_W   = 12,
   parameter int NEG_STYLE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lbl_sin,
   input  logic               lbl_shift,
   input  logic               lbl_load,
   input  logic               start,
   input  logic [ALPHA_W-1:0] alpha,
   output logic               sign_o,
   output logic               zero_o,
   output logic               done_o
);

   localparam int TOT_W = total_bits(ALPHA_W, NUM_PAT);

   initial begin
      assert (NUM_PAT >= 2) else $error("NUM_PAT must be at least 2");
      assert (ALPHA_W >= 1) else $error("ALPHA_W must be at least 1");
      assert (NEG_STYLE == 0 || NEG_STYLE == 1) else $error("NEG_STYLE must be 0 or 1");
   end

   logic             go;
   logic             step_en;
   logic             done;
   logic             head;
   logic             ld_en;
   logic             rot_en;
   logic [TOT_W-1:0] term;
   logic [TOT_W-1:0] total;

   assign ld_en  = lbl_shift && lbl_load && !step_en;
   assign rot_en = step_en || (lbl_shift && !lbl_load && !step_en);

   pass_seq #(.NUM_PAT(NUM_PAT)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .go      (go),
      .step_en (step_en),
      .done    (done)
   );

   label_ring #(.NUM_PAT(NUM_PAT)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .rot_en   (rot_en),
      .din_bit  (lbl_sin),
      .pass_go  (go),
      .pass_fin (done),
      .head_bit (head)
   );

   signed_pick #(.ALPHA_W(ALPHA_W), .TOT_W(TOT_W), .NEG_STYLE(NEG_STYLE)) u_pick (
      .alpha (alpha),
      .plus  (head),
      .term  (term)
   );

   total_acc #(.TOT_W(TOT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .en    (step_en),
      .term  (term),
      .total (total)
   );

   assign sign_o = total[TOT_W-1];
   assign zero_o = (total == '0);
   assign done_o = done;

   // R7: adding a non-negative term to a non-negative total never flips the sign
   p_no_overflow_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && !go && !term[TOT_W-1] && !total[TOT_W-1] |=> !sign_o);

   // R7: likewise for negative plus negative
   p_no_overflow_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && !go && term[TOT_W-1] && total[TOT_W-1] |=> sign_o);

   // R6: zero and negative are exclusive
   p_zero_not_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o |-> !sign_o);

   // R6: outside a pass the reported result holds
   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en && !go |=> $stable(sign_o) && $stable(zero_o));

endmodule

// File: tb/label_sum_sign_test.sv
module label_sum_sign_test;

   localparam int NP = 8;
   localparam int AW = 12;
   localparam int AMAX = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lbl_sin = 1'b0;
   logic          lbl_shift = 1'b0;
   logic          lbl_load = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] alpha = '0;
   logic          sign_o, zero_o, done_o;

   int errors = 0;
   int checks = 0;

   int alph [NP];
   bit lab  [NP];

   // reference model state
   int m_acc;
   bit m_busy;
   int m_cnt;
   bit m_done;
   bit m_ring [$];

   always #5 clk = ~clk;

   label_sum_sign #(.NUM_PAT(NP), .ALPHA_W(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lbl_sin   (lbl_sin),
      .lbl_shift (lbl_shift),
      .lbl_load  (lbl_load),
      .start     (start),
      .alpha     (alpha),
      .sign_o    (sign_o),
      .zero_o    (zero_o),
      .done_o    (done_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural model, updated at each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_busy = 0; m_cnt = 0; m_done = 0;
         m_ring.delete();
         for (int i = 0; i < NP; i++) m_ring.push_back(1'b0);
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (m_ring[0]) m_acc = m_acc + int'(alpha);
            else           m_acc = m_acc - int'(alpha);
            m_ring.push_back(m_ring.pop_front());
            m_cnt++;
            if (m_cnt == NP) begin m_busy = 0; m_done = 1; end
         end else begin
            if (lbl_shift) begin
               if (lbl_load) begin void'(m_ring.pop_front()); m_ring.push_back(lbl_sin); end
               else m_ring.push_back(m_ring.pop_front());
            end
            if (start) begin m_acc = 0; m_busy = 1; m_cnt = 0; end
         end
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5", "model done", int'(done_o), int'(m_done));
         chk("R6", "model sign", int'(sign_o), int'(m_acc < 0));
         chk("R6", "model zero", int'(zero_o), int'(m_acc == 0));
      end
   end

   function automatic int exp_sum();
      int s = 0;
      for (int k = 0; k < NP; k++) s += lab[k] ? alph[k] : -alph[k];
      return s;
   endfunction

   task automatic load_labels();
      for (int k = 0; k < NP; k++) begin
         lbl_shift = 1'b1; lbl_load = 1'b1; lbl_sin = lab[k];
         @(negedge clk);
      end
      lbl_shift = 1'b0; lbl_load = 1'b0; lbl_sin = 1'b0;
   endtask

   task automatic run_pass(input string req, input bit poke);
      int s;
      s = exp_sum();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < NP; k++) begin
         alpha = AW'(alph[k]);
         if (poke && k == 3) begin
            start = 1'b1; lbl_shift = 1'b1; lbl_load = 1'b1; lbl_sin = ~lab[0];
         end else begin
            start = 1'b0; lbl_shift = 1'b0; lbl_load = 1'b0; lbl_sin = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0; lbl_shift = 1'b0; lbl_load = 1'b0; alpha = '0;
      chk("R5", "done at pass end", int'(done_o), 1);
      chk(req, "sign", int'(sign_o), int'(s < 0));
      chk(req, "zero", int'(zero_o), int'(s == 0));
      @(negedge clk);
      chk("R5", "done one cycle", int'(done_o), 0);
      chk("R6", "sign held", int'(sign_o), int'(s < 0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      bit tmp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sign after reset", int'(sign_o), 0);
      chk("R1", "zero after reset", int'(zero_o), 1);
      chk("R1", "done after reset", int'(done_o), 0);

      // R1: labels reset to 0, so every multiplier is subtracted
      for (int k = 0; k < NP; k++) begin alph[k] = 5; lab[k] = 0; end
      run_pass("R1", 0);

      // R2 R4: mixed labels, positive total
      lab = '{1,0,1,1,0,0,1,0};
      alph = '{100,200,300,50,7,900,4095,1};
      load_labels();
      run_pass("R2", 0);

      // R8: repeat over the same multipliers
      run_pass("R8", 0);

      // R4: negative total with the same labels
      alph = '{1,2000,3,4,1500,1600,10,700};
      run_pass("R4", 0);

      // R3: rotate by one place without loading
      lbl_shift = 1'b1; lbl_load = 1'b0; lbl_sin = 1'b1;
      @(negedge clk);
      lbl_shift = 1'b0; lbl_sin = 1'b0;
      tmp = lab[0];
      for (int k = 0; k < NP - 1; k++) lab[k] = lab[k + 1];
      lab[NP - 1] = tmp;
      run_pass("R3", 0);

      // R9: start and shift poked mid-pass, then a clean pass
      run_pass("R9", 1);
      run_pass("R9", 0);

      // R7: full-scale all add, then all subtract
      for (int k = 0; k < NP; k++) begin lab[k] = 1; alph[k] = AMAX; end
      load_labels();
      run_pass("R7", 0);
      for (int k = 0; k < NP; k++) lab[k] = 0;
      load_labels();
      run_pass("R7", 0);

      // R6: balanced pairs give exactly zero
      lab = '{1,0,1,0,1,0,1,0};
      alph = '{37,37,4000,4000,1,1,999,999};
      load_labels();
      run_pass("R6", 0);

      repeat (2) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule